// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master on a wired-AND bus. It does not drive the line high itself. It only enables an open-drain pull-down, and it reads the bus level back through a pulse-width filter. Another master or a slave that holds the line low therefore lengthens the low phase. A device that pulls the line low during the generator's high phase cuts that high phase short. The clock period is picked from seven powers of two. The high phase is always 8 input clocks longer than the low phase.

A transfer request starts one byte phase. The generator clocks out a programmable number of data bits and may add one acknowledge clock. After the last clock it finishes a final low phase, raises a one-cycle done pulse, and keeps the line pulled low until the next request. A start-condition pulse forces the following transfer to 8 bits, so that an address-plus-direction byte is always complete. The divider and bit-count settings are captured when a request is accepted.

The FSM has six states:
- IDLE (released, after reset).
- LOW (counting the low phase).
- WAIT_HI (released, waiting for the filtered line to read high).
- HIGH (counting the high phase).
- FINISH (done pulse).
- PARK (held low between transfers).

Transitions:
- IDLE or PARK go to LOW on a request.
- LOW goes to WAIT_HI when the low count expires and clocks remain.
- LOW goes to FINISH when the low count expires and no clocks remain.
- WAIT_HI goes to HIGH once the filtered line reads high.
- HIGH goes to LOW when the high count expires or the filtered line drops.
- FINISH goes to PARK.

Top module: `scl_master_clkgen`

## Requirements
- R1: Reset is synchronous. While it is asserted and afterwards, `scl_pull_low` is 0 (line released), `bit_strobe` and `done_pulse` are 0, and the line stays released until the first request.
- R2: `freq_sel` codes 0..6 select exponent n = 4..10, and code 7 selects n = 10. Every low phase that nobody stretches lasts exactly 2^n input clocks of `scl_pull_low` = 1.
- R3: With no other device holding the line low, `scl_pull_low` stays 0 for exactly 2^n + 8 input clocks between two low phases. The time the filter needs to see the line high is included in that count.
- R4: `bit_cnt_sel` code 0 means 8 data bits, and codes 1..7 mean 1..7 data bits. `bit_strobe` pulses once, in the last cycle of the high phase, for each data-bit clock.
- R5: A `start_pulse` received while idle or in the same cycle as the request forces the next accepted transfer to 8 data bits. Later transfers use `bit_cnt_sel` again.
- R6: When `ack_en` is 1 at the request, one extra clock pulse follows the data bits, and no `bit_strobe` is raised for it.
- R7: After the last clock, a low phase of 2^n cycles completes. `done_pulse` is then high for exactly one cycle, and `scl_pull_low` stays 1 until the next request.
- R8: If another device keeps the line low for D cycles after this block releases it, that release lasts 2^n + 8 + D cycles.
- R9: If the line is held low for at least 16 cycles during a high phase, the high phase is abandoned. `scl_pull_low` returns to 1 one cycle after the filter recognises the low level, which is 17 cycles after the line first reads low. A full low phase of 2^n cycles then follows, and the abandoned clock still counts as a bit.
- R10: A line level change that lasts fewer than 16 consecutive input clocks is not recognised and leaves the clock timing unchanged.
- R11: `xfer_req`, `freq_sel`, `bit_cnt_sel` and `ack_en` have no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_sel | input | 3 | Divider exponent select |
| bit_cnt_sel | input | 3 | Data bits per transfer (0 means 8) |
| ack_en | input | 1 | Add an acknowledge clock after the data bits |
| start_pulse | input | 1 | Start condition seen; forces the next transfer to 8 bits |
| xfer_req | input | 1 | Begin a byte phase when idle or parked |
| scl_in | input | 1 | Sampled bus clock level |
| scl_pull_low | output | 1 | Open-drain pull-down enable for the clock line |
| bit_strobe | output | 1 | One-cycle strobe at the end of each data-bit clock |
| done_pulse | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a start condition and a transfer request. The bench raises `start_pulse` and `xfer_req` together with a nonzero bit-count field and expects eight strobes. The next request, without a start, must again follow the field.

The second pair is a request arriving while a transfer is running. In the same cycle the bench also changes the divider, the bit count and the acknowledge flag. The scoreboard then judges that transfer's pulse count, phase widths and final low against the values captured at the original request.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_WAIT_HI,
        ST_HIGH,
        ST_FINISH,
        ST_PARK
    } scl_state_t;

endpackage

// File: rtl/scl_period_sel.sv
module scl_period_sel #(
    parameter int N_BASE   = 4,
    parameter int N_STEPS  = 7,
    parameter int HI_EXTRA = 8,
    parameter int FILT_LEN = 16,
    parameter int CNT_W    = 11
) (
    input  logic [2:0]       code,
    output logic [CNT_W-1:0] lo_last,
    output logic [CNT_W-1:0] hi_last
);
    localparam int CODES = 8;
    localparam int N_TOP = N_BASE + N_STEPS - 1;

    logic [CNT_W:0] len_tbl [CODES];
    logic [CNT_W:0] lo_len;

    // One entry per code; codes past the last step clamp to the slowest rate
    for (genvar g = 0; g < CODES; g++) begin : g_len
        localparam int EXP = (g < N_STEPS) ? (N_BASE + g) : N_TOP;
        assign len_tbl[g] = (CNT_W + 1)'(2 ** EXP);
    end

    always_comb begin
        lo_len  = len_tbl[code];
        lo_last = CNT_W'(lo_len - (CNT_W + 1)'(1));
        // High count starts only after the filter has seen the line high,
        // so its limit is shortened by the filter delay plus the hand-off cycles
        hi_last = CNT_W'(lo_len + (CNT_W + 1)'(HI_EXTRA) - (CNT_W + 1)'(FILT_LEN + 2));
    end

endmodule

// File: rtl/scl_level_filter.sv
module scl_level_filter #(
    parameter int FILT_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic filt_out
);
    localparam int FW = $clog2(FILT_LEN + 1);

    logic          filt_q;
    logic [FW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b1;
            run_q  <= '0;
        end else if (raw_in == filt_q) begin
            run_q <= '0;
        end else if (run_q == FW'(FILT_LEN - 1)) begin
            filt_q <= raw_in;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign filt_out = filt_q;

    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (raw_in == filt_q) |=> $stable(filt_q)); // R10

endmodule

// File: rtl/scl_pulse_budget.sv
module scl_pulse_budget #(
    parameter int DATA_MAX = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_pulse,
    input  logic       load,
    input  logic [2:0] bit_code,
    input  logic       ack_en,
    input  logic       pulse_done,
    output logic       is_data,
    output logic       all_done
);
    localparam int BW = $clog2(DATA_MAX + 1);

    logic          force_q;
    logic [BW-1:0] data_left_q;
    logic          ack_left_q;
    logic [BW-1:0] field_bits;

    assign field_bits = (bit_code == 3'd0) ? BW'(DATA_MAX) : BW'(bit_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q     <= 1'b0;
            data_left_q <= '0;
            ack_left_q  <= 1'b0;
        end else if (load) begin
            data_left_q <= (force_q || start_pulse) ? BW'(DATA_MAX) : field_bits;
            ack_left_q  <= ack_en;
            force_q     <= 1'b0;
        end else begin
            if (start_pulse) force_q <= 1'b1;
            if (pulse_done) begin
                if (data_left_q != '0) data_left_q <= data_left_q - 1'b1;
                else                   ack_left_q  <= 1'b0;
            end
        end
    end

    assign is_data  = (data_left_q != '0);
    assign all_done = (data_left_q == '0) && !ack_left_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        data_left_q <= BW'(DATA_MAX)); // R4
    AST_START_FORCES: assert property (@(posedge clk) disable iff (rst)
        (load && start_pulse) |=> (data_left_q == BW'(DATA_MAX))); // R5

endmodule

// File: rtl/scl_master_clkgen.sv
module scl_master_clkgen #(
    parameter int N_BASE   = 4,
    parameter int N_STEPS  = 7,
    parameter int HI_EXTRA = 8,
    parameter int FILT_LEN = 16,
    parameter int DATA_MAX = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] freq_sel,
    input  logic [2:0] bit_cnt_sel,
    input  logic       ack_en,
    input  logic       start_pulse,
    input  logic       xfer_req,
    input  logic       scl_in,
    output logic       scl_pull_low,
    output logic       bit_strobe,
    output logic       done_pulse
);
    import sclgen_pkg::*;

    localparam int N_TOP = N_BASE + N_STEPS - 1;
    localparam int CNT_W = $clog2((2 ** N_TOP) + HI_EXTRA + 1);

    scl_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       fs_q;
    logic [CNT_W-1:0] lo_last, hi_last;
    logic             filt;
    logic             is_data, all_done;
    logic             load, hi_end;

    scl_period_sel #(
        .N_BASE(N_BASE), .N_STEPS(N_STEPS), .HI_EXTRA(HI_EXTRA),
        .FILT_LEN(FILT_LEN), .CNT_W(CNT_W)
    ) u_period (
        .code(fs_q), .lo_last(lo_last), .hi_last(hi_last)
    );

    scl_level_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk(clk), .rst(rst), .raw_in(scl_in), .filt_out(filt)
    );

    scl_pulse_budget #(.DATA_MAX(DATA_MAX)) u_budget (
        .clk(clk), .rst(rst), .start_pulse(start_pulse), .load(load),
        .bit_code(bit_cnt_sel), .ack_en(ack_en), .pulse_done(hi_end),
        .is_data(is_data), .all_done(all_done)
    );

    assign load   = ((state_q == ST_IDLE) || (state_q == ST_PARK)) && xfer_req;
    assign hi_end = (state_q == ST_HIGH) && (!filt || (cnt_q == hi_last));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (xfer_req) state_d = ST_LOW;
            ST_PARK:    if (xfer_req) state_d = ST_LOW;
            ST_LOW:     if (cnt_q == lo_last) state_d = all_done ? ST_FINISH : ST_WAIT_HI;
            ST_WAIT_HI: if (filt) state_d = ST_HIGH;
            ST_HIGH:    if (hi_end) state_d = ST_LOW;
            ST_FINISH:  state_d = ST_PARK;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            fs_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if ((state_q == ST_LOW) || (state_q == ST_HIGH))
                cnt_q <= cnt_q + 1'b1;
            if (load) fs_q <= freq_sel;
        end
    end

    always_comb begin
        scl_pull_low = 1'b0;
        done_pulse   = 1'b0;
        bit_strobe   = 1'b0;
        unique case (state_q)
            ST_LOW:    scl_pull_low = 1'b1;
            ST_PARK:   scl_pull_low = 1'b1;
            ST_FINISH: begin
                scl_pull_low = 1'b1;
                done_pulse   = 1'b1;
            end
            ST_HIGH:   bit_strobe = hi_end && is_data;
            default:   ;
        endcase
    end

    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> !scl_pull_low); // R1
    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW) |-> (cnt_q <= lo_last)); // R2
    AST_STROBE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |-> !scl_pull_low); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> (!done_pulse && scl_pull_low)); // R7
    AST_ABANDON_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_HIGH) && !filt) |=> scl_pull_low); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_LOW) || (state_q == ST_WAIT_HI) || (state_q == ST_HIGH))
        |=> $stable(fs_q)); // R11

endmodule

// File: tb/scl_master_clkgen_test.sv
module scl_master_clkgen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] freq_sel = '0;
    logic [2:0] bit_cnt_sel = '0;
    logic       ack_en = 1'b0;
    logic       start_pulse = 1'b0;
    logic       xfer_req = 1'b0;
    logic       ext_hold = 1'b0;
    logic       scl_pull_low, bit_strobe, done_pulse;
    wire        scl_line = !(scl_pull_low || ext_hold);

    always #10 clk = ~clk;

    scl_master_clkgen uut (
        .clk(clk), .rst(rst), .freq_sel(freq_sel), .bit_cnt_sel(bit_cnt_sel),
        .ack_en(ack_en), .start_pulse(start_pulse), .xfer_req(xfer_req),
        .scl_in(scl_line), .scl_pull_low(scl_pull_low), .bit_strobe(bit_strobe),
        .done_pulse(done_pulse)
    );

    typedef struct {
        int    lo;
        int    nbits;
        int    pulses;
        int    rel_min;
        int    rel_max;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0, errors = 0;
    bit finished = 0;
    bit force_pending = 0;

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor state
    logic prev_pull = 1'b0;
    int   run = 0;
    bit   xfer_live = 0, rel_mark = 0, seen_rel = 0, got_done = 0;
    int   strobes = 0, pulses = 0, n_low = 0;
    int   rel_min = 1 << 30, rel_max = 0, low_min = 1 << 30, low_max = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (scl_pull_low == prev_pull) run++;
            else begin
                if (prev_pull == 1'b0) begin
                    if (rel_mark) begin
                        pulses++;
                        if (run < rel_min) rel_min = run;
                        if (run > rel_max) rel_max = run;
                        seen_rel = 1;
                    end
                    rel_mark = 0;
                end else begin
                    if (seen_rel) begin
                        n_low++;
                        if (run < low_min) low_min = run;
                        if (run > low_max) low_max = run;
                    end
                    rel_mark = xfer_live;
                end
                run = 1;
            end
            prev_pull = scl_pull_low;
            if (bit_strobe) strobes++;
            if (done_pulse) begin
                if (sbq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected done: actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(e.tag, "clock pulses (R4/R6)", pulses, e.pulses);
                    check(e.tag, "data strobes (R4)", strobes, e.nbits);
                    check(e.tag, "shortest release (R3)", rel_min, e.rel_min);
                    check(e.tag, "longest release (R3)", rel_max, e.rel_max);
                    check(e.tag, "final low before done (R7)", run - 1, e.lo);
                    if (e.pulses >= 2) begin
                        check(e.tag, "inner lows (R2)", n_low, e.pulses - 1);
                        check(e.tag, "low min (R2)", low_min, e.lo);
                        check(e.tag, "low max (R2)", low_max, e.lo);
                    end
                end
                strobes = 0; pulses = 0; n_low = 0; seen_rel = 0; rel_mark = 0;
                rel_min = 1 << 30; rel_max = 0; low_min = 1 << 30; low_max = 0;
                xfer_live = 0;
                got_done = 1;
            end
        end
    end

    // external device model: 1 stretch, 2 abandon, 3 glitch
    int   ext_mode = 0, ext_d = 0, ext_k = 0;
    bit   ext_arm = 0, ext_run = 0;
    logic ext_pp = 1'b0;

    always @(negedge clk) begin
        if (ext_arm && ext_pp && !scl_pull_low) begin
            ext_k = 0; ext_arm = 0; ext_run = 1;
        end else if (ext_run) begin
            ext_k++;
            if (ext_mode != 1 && ext_k == 30) ext_hold = 1'b1;
            if (ext_k == ext_d) begin ext_hold = 1'b0; ext_run = 0; end
        end
        ext_pp = scl_pull_low;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
            finish_run();
        end
    end

    task automatic start_only();
        @(negedge clk); start_pulse = 1'b1; force_pending = 1;
        @(negedge clk); start_pulse = 1'b0;
    endtask

    task automatic run_xfer(input int fcode, input int bcode, input int ackv, input int st,
                            input int mode, input int d, input int poke, input string tag);
        exp_t e;
        int   n, nb;
        n  = (fcode >= 7) ? 10 : 4 + fcode;
        nb = (st != 0 || force_pending) ? 8 : ((bcode == 0) ? 8 : bcode);
        force_pending = 0;
        e.lo = 1 << n;
        e.nbits = nb;
        e.pulses = nb + ackv;
        e.rel_min = e.lo + 8;
        e.rel_max = e.lo + 8;
        if (mode == 1) e.rel_max = e.lo + 8 + d;
        if (mode == 2) e.rel_min = 30 + 17;
        e.tag = tag;
        sbq.push_back(e);
        ext_mode = mode; ext_d = d; ext_arm = (mode != 0);
        @(negedge clk);
        freq_sel = 3'(fcode); bit_cnt_sel = 3'(bcode); ack_en = (ackv != 0);
        start_pulse = (st != 0); xfer_req = 1'b1; xfer_live = 1; got_done = 0;
        if (mode == 1) ext_hold = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0; start_pulse = 1'b0;
        if (poke != 0) begin
            repeat (30) @(negedge clk);
            xfer_req = 1'b1; freq_sel = 3'd6; bit_cnt_sel = 3'd7; ack_en = 1'b1;
            @(negedge clk);
            xfer_req = 1'b0;
        end
        while (!got_done) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1", "pull during reset", int'(scl_pull_low), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pull after reset", int'(scl_pull_low), 0);
        check("R1", "done after reset", int'(done_pulse), 0);
        check("R1", "strobe after reset", int'(bit_strobe), 0);
        repeat (40) @(negedge clk);
        check("R1", "pull while idle", int'(scl_pull_low), 0);

        run_xfer(0, 0, 0, 0, 0, 0, 0, "R2_R3_R4 code0 eight bits");
        repeat (5) @(negedge clk);
        check("R7", "pull held after done", int'(scl_pull_low), 1);
        check("R7", "done is single cycle", int'(done_pulse), 0);

        run_xfer(1, 3, 1, 0, 0, 0, 0, "R6 three bits plus ack");
        run_xfer(0, 5, 0, 1, 0, 0, 0, "R5 start with request");
        run_xfer(0, 5, 0, 0, 0, 0, 0, "R5 field kept");
        start_only();
        repeat (3) @(negedge clk);
        run_xfer(0, 2, 0, 0, 0, 0, 0, "R5 start while parked");
        run_xfer(2, 2, 0, 0, 1, 40, 0, "R8 stretched release");
        run_xfer(2, 2, 0, 0, 2, 50, 0, "R9 abandoned high");
        run_xfer(2, 2, 0, 0, 3, 40, 0, "R10 short glitch");
        run_xfer(0, 1, 0, 0, 0, 0, 1, "R11 busy request");
        run_xfer(7, 1, 0, 0, 0, 0, 0, "R2 code7 clamps");
        run_xfer(6, 1, 1, 0, 0, 0, 0, "R2 code6 slowest");
        repeat (5) @(negedge clk);
        check("R7", "parked after last", int'(scl_pull_low), 1);
        check("R11", "queue drained", sbq.size(), 0);
        finish_run();
    end

endmodule